// File: doc/BRIEF.md
# Debug Breakpoint Trigger Comparator

This block is the first-level match stage of an on-chip debug trigger. Each cycle it checks three things against registers it holds: the program counter of the retiring instruction, the address of a load/store operand, and the operand's data value. It raises a single trigger bit when every enabled comparator class agrees. The halt, interrupt and multi-level sequencing logic downstream uses that bit.

The program-counter class holds four breakpoint addresses. Slot 0 has a per-bit don't-care mask. Slots 1 to 3 compare every bit exactly and each has its own valid bit. The address class holds a low and a high bound and offers three modes: equal-to-low, inside the inclusive range, and outside the range. The data class holds one reference value. The PC class and the data class each have an invert control, so a match can mean "not this". Configuration goes through a write-only port addressed by a 5-bit register index. The stored values cannot be read back.

Top module: `dbg_trig_unit`

## Requirements
- R1: After reset the trigger output is low, and every enable and valid bit is zero. No trigger fires until the control word is written.
- R2: PC slot 0 matches when the PC equals the slot value in every bit position where the mask register holds 0. A mask bit of 1 removes that position from the compare.
- R3: PC slots 1, 2 and 3 compare all bits exactly and ignore the mask. Slot k (k = 1..3) takes part only while control bit 6+k is set.
- R4: Control bit 1 enables the PC class. The PC class can match only in a cycle where `inst_valid` is high. If the PC class is enabled and `inst_valid` is low, no trigger results.
- R5: Control bit 0 inverts the PC class. With bit 0 clear, a PC inside the region (any active slot matching) is a hit. With bit 0 set, a PC outside the region is a hit.
- R6: Control bits 4:2 select the address modes. Bit 2 hits on an address equal to the low bound. Bit 3 hits when low <= address <= high. Bit 4 hits when the address is below low or above high. If several mode bits are set, their results are ORed. If all three are clear, the address class is disabled. The address class can match only while `op_valid` is high.
- R7: Control bit 6 enables the data class. It hits when `op_data` equals the reference value and `op_valid` is high. Control bit 5 inverts the equality, so any other value hits.
- R8: The trigger is the AND of all enabled classes. If no class is enabled, the trigger stays low.
- R9: The trigger is registered. It reflects the inputs presented in the previous clock cycle.
- R10: The register indices are: 0x08 to 0x0B for PC slots 0 to 3, 0x0C for the slot-0 mask, 0x0D for the low bound, 0x0E for the high bound, 0x0F for the data reference, and 0x10 for the control word. A write to any other index changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 5 | Register index of the write |
| wr_data | input | WRW | Write value (WRW = widest of AW, DW, control word) |
| inst_valid | input | 1 | A retiring instruction's PC is on `pc` |
| pc | input | AW | Program counter of the retiring instruction |
| op_valid | input | 1 | An operand access is on `op_addr`/`op_data` |
| op_addr | input | AW | Operand address |
| op_data | input | DW | Operand data value |
| trig_o | output | 1 | Registered trigger pulse |

## Verification
The bench runs an 8-bit configuration and sweeps every PC, address and data value for each mode and mask setting. This exposes a mask with inverted polarity or one applied to slots 1 to 3, since those designs fire on PCs that differ in masked-out or unmasked bits. It also exposes a range compare with an off-by-one at the low or high bound: that design drops or adds the boundary address, and the equal-to-low mode then disagrees with the inclusive mode. Slots 1 to 3 are swept with their valid bits both clear and set, which catches a valid bit that is ignored or mapped to the wrong slot. Writes to unused indices around the map's edges are checked for side effects. The one-cycle latency is checked in the cycle before and the cycle after the capturing edge, so a trigger built without the output register is also reported.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

  localparam int IDXW      = 5;
  localparam int PC_SLOTS  = 4;
  localparam int CTRL_W    = 7 + PC_SLOTS - 1;

  localparam logic [IDXW-1:0] IDX_PC0  = 5'h08;
  localparam logic [IDXW-1:0] IDX_MASK = 5'h0C;
  localparam logic [IDXW-1:0] IDX_LO   = 5'h0D;
  localparam logic [IDXW-1:0] IDX_HI   = 5'h0E;
  localparam logic [IDXW-1:0] IDX_DREF = 5'h0F;
  localparam logic [IDXW-1:0] IDX_CTRL = 5'h10;

  // address mode bit positions inside amode
  localparam int AM_EQ_LO  = 0;
  localparam int AM_INSIDE = 1;
  localparam int AM_OUTSIDE = 2;

  typedef struct packed {
    logic [PC_SLOTS-2:0] slot_valid; // bits 9:7
    logic                dat_en;     // bit 6
    logic                dat_inv;    // bit 5
    logic [2:0]          amode;      // bits 4:2
    logic                pc_en;      // bit 1
    logic                pc_inv;     // bit 0
  } trig_ctrl_t;

endpackage

// File: rtl/dbg_trig_regs.sv
module dbg_trig_regs
  import dbg_trig_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int WRW = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [IDXW-1:0]               wr_idx,
  input  logic [WRW-1:0]                wr_data,
  output logic [PC_SLOTS-1:0][AW-1:0]   slot_q,
  output logic [AW-1:0]                 mask_q,
  output logic [AW-1:0]                 lo_q,
  output logic [AW-1:0]                 hi_q,
  output logic [DW-1:0]                 dref_q,
  output trig_ctrl_t                    ctrl_q
);

  function automatic logic hit_idx(input logic en, input logic [IDXW-1:0] idx,
                                   input logic [IDXW-1:0] slot);
    return en && (idx == slot);
  endfunction

  // Value registers carry no reset: enables below keep them inert.
  for (genvar g = 0; g < PC_SLOTS; g++) begin : g_slot
    localparam logic [IDXW-1:0] SLOT_IDX = IDX_PC0 + IDXW'(g);
    always_ff @(posedge clk) begin
      if (hit_idx(wr_en, wr_idx, SLOT_IDX)) slot_q[g] <= wr_data[AW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (hit_idx(wr_en, wr_idx, IDX_MASK)) mask_q <= wr_data[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (hit_idx(wr_en, wr_idx, IDX_LO)) lo_q <= wr_data[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (hit_idx(wr_en, wr_idx, IDX_HI)) hi_q <= wr_data[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (hit_idx(wr_en, wr_idx, IDX_DREF)) dref_q <= wr_data[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                ctrl_q <= '0;
    else if (hit_idx(wr_en, wr_idx, IDX_CTRL)) ctrl_q <= trig_ctrl_t'(wr_data[CTRL_W-1:0]);
  end

endmodule

// File: rtl/dbg_pc_cmp.sv
module dbg_pc_cmp
  import dbg_trig_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                        inst_valid,
  input  logic [AW-1:0]               pc,
  input  logic [PC_SLOTS-1:0][AW-1:0] slot_q,
  input  logic [AW-1:0]               mask_q,
  input  logic [PC_SLOTS-2:0]         slot_valid,
  input  logic                        pc_en,
  input  logic                        pc_inv,
  output logic                        pc_hit
);

  // a set mask bit removes that position from the compare
  function automatic logic masked_eq(input logic [AW-1:0] a, input logic [AW-1:0] b,
                                     input logic [AW-1:0] m);
    return ((a ^ b) & ~m) == '0;
  endfunction

  logic [PC_SLOTS-1:0] slot_hit;
  logic                in_region;

  for (genvar g = 0; g < PC_SLOTS; g++) begin : g_cmp
    if (g == 0) begin : g_masked
      assign slot_hit[g] = masked_eq(pc, slot_q[g], mask_q);
    end else begin : g_exact
      assign slot_hit[g] = slot_valid[g-1] && (pc == slot_q[g]);
    end
  end

  assign in_region = |slot_hit;
  assign pc_hit    = pc_en && inst_valid && (in_region ^ pc_inv);

endmodule

// File: rtl/dbg_addr_cmp.sv
module dbg_addr_cmp
  import dbg_trig_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          op_valid,
  input  logic [AW-1:0] op_addr,
  input  logic [AW-1:0] lo_q,
  input  logic [AW-1:0] hi_q,
  input  logic [2:0]    amode,
  output logic          addr_en,
  output logic          addr_hit
);

  function automatic logic in_span(input logic [AW-1:0] a, input logic [AW-1:0] lo,
                                   input logic [AW-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  logic [2:0] mode_hit;

  always_comb begin
    mode_hit             = '0;
    mode_hit[AM_EQ_LO]   = (op_addr == lo_q);
    mode_hit[AM_INSIDE]  = in_span(op_addr, lo_q, hi_q);
    mode_hit[AM_OUTSIDE] = !in_span(op_addr, lo_q, hi_q);
  end

  assign addr_en  = |amode;
  assign addr_hit = op_valid && |(mode_hit & amode);

endmodule

// File: rtl/dbg_data_cmp.sv
module dbg_data_cmp #(
  parameter int DW = 32
) (
  input  logic          op_valid,
  input  logic [DW-1:0] op_data,
  input  logic [DW-1:0] dref_q,
  input  logic          dat_en,
  input  logic          dat_inv,
  output logic          data_hit
);

  logic data_eq;

  assign data_eq  = (op_data == dref_q);
  assign data_hit = dat_en && op_valid && (data_eq ^ dat_inv);

endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
  import dbg_trig_pkg::*;
#(
  parameter  int AW  = 32,
  parameter  int DW  = 32,
  localparam int WRW = (AW > DW) ? ((AW > CTRL_W) ? AW : CTRL_W)
                                 : ((DW > CTRL_W) ? DW : CTRL_W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [WRW-1:0]  wr_data,
  input  logic            inst_valid,
  input  logic [AW-1:0]   pc,
  input  logic            op_valid,
  input  logic [AW-1:0]   op_addr,
  input  logic [DW-1:0]   op_data,
  output logic            trig_o
);

  logic [PC_SLOTS-1:0][AW-1:0] slot_q;
  logic [AW-1:0]               mask_q;
  logic [AW-1:0]               lo_q;
  logic [AW-1:0]               hi_q;
  logic [DW-1:0]               dref_q;
  trig_ctrl_t                  ctrl_q;

  // named events for the checker
  logic pc_en_w, addr_en_w, data_en_w;
  logic pc_hit, addr_hit, data_hit;
  logic armed, trig_d;

  dbg_trig_regs #(.AW(AW), .DW(DW), .WRW(WRW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .slot_q(slot_q), .mask_q(mask_q), .lo_q(lo_q), .hi_q(hi_q),
    .dref_q(dref_q), .ctrl_q(ctrl_q)
  );

  dbg_pc_cmp #(.AW(AW)) u_pc (
    .inst_valid(inst_valid), .pc(pc), .slot_q(slot_q), .mask_q(mask_q),
    .slot_valid(ctrl_q.slot_valid), .pc_en(ctrl_q.pc_en), .pc_inv(ctrl_q.pc_inv),
    .pc_hit(pc_hit)
  );

  dbg_addr_cmp #(.AW(AW)) u_addr (
    .op_valid(op_valid), .op_addr(op_addr), .lo_q(lo_q), .hi_q(hi_q),
    .amode(ctrl_q.amode), .addr_en(addr_en_w), .addr_hit(addr_hit)
  );

  dbg_data_cmp #(.DW(DW)) u_data (
    .op_valid(op_valid), .op_data(op_data), .dref_q(dref_q),
    .dat_en(ctrl_q.dat_en), .dat_inv(ctrl_q.dat_inv), .data_hit(data_hit)
  );

  function automatic logic class_ok(input logic en, input logic hit);
    return !en || hit;
  endfunction

  assign pc_en_w   = ctrl_q.pc_en;
  assign data_en_w = ctrl_q.dat_en;
  assign armed     = pc_en_w || addr_en_w || data_en_w;
  assign trig_d    = armed && class_ok(pc_en_w, pc_hit)
                           && class_ok(addr_en_w, addr_hit)
                           && class_ok(data_en_w, data_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_o <= 1'b0;
    else        trig_o <= trig_d;
  end

endmodule

// File: rtl/dbg_trig_chk.sv
module dbg_trig_chk (
  input logic clk,
  input logic rst_n,
  input logic inst_valid,
  input logic op_valid,
  input logic pc_en_w,
  input logic addr_en_w,
  input logic data_en_w,
  input logic pc_hit,
  input logic addr_hit,
  input logic data_hit,
  input logic trig_o
);

  assert_unarmed_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pc_en_w || addr_en_w || data_en_w) |=> !trig_o);

  assert_pc_needs_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_en_w && !inst_valid) |=> !trig_o);

  assert_op_needs_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr_en_w || data_en_w) && !op_valid) |=> !trig_o);

  assert_pc_miss_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_en_w && !pc_hit) |=> !trig_o);

  assert_addr_miss_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_en_w && !addr_hit) |=> !trig_o);

  assert_data_miss_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_en_w && !data_hit) |=> !trig_o);

  assert_fire_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> $past(pc_hit || addr_hit || data_hit));

endmodule

bind dbg_trig_unit dbg_trig_chk u_chk (
  .clk(clk), .rst_n(rst_n), .inst_valid(inst_valid), .op_valid(op_valid),
  .pc_en_w(pc_en_w), .addr_en_w(addr_en_w), .data_en_w(data_en_w),
  .pc_hit(pc_hit), .addr_hit(addr_hit), .data_hit(data_hit), .trig_o(trig_o)
);

// File: tb/dbg_trig_unit_bench.sv
module dbg_trig_unit_bench;

  localparam int W   = 8;
  localparam int WRW = 10;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [4:0]     wr_idx = '0;
  logic [WRW-1:0] wr_data = '0;
  logic           inst_valid = 1'b0;
  logic [W-1:0]   pc = '0;
  logic           op_valid = 1'b0;
  logic [W-1:0]   op_addr = '0;
  logic [W-1:0]   op_data = '0;
  logic           trig_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // bench copy of the configuration, maintained from the requirements
  logic [W-1:0] m_slot [4];
  logic [W-1:0] m_mask = '0, m_lo = '0, m_hi = '0, m_dref = '0;
  logic [9:0]   m_ctl = '0;

  always #5 clk = ~clk;

  dbg_trig_unit #(.AW(W), .DW(W)) u_dbg_trig_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .inst_valid(inst_valid), .pc(pc), .op_valid(op_valid), .op_addr(op_addr),
    .op_data(op_data), .trig_o(trig_o)
  );

  function automatic bit model(bit iv, logic [W-1:0] p, bit ov, logic [W-1:0] a,
                               logic [W-1:0] d);
    bit region = 1'b1;
    bit pc_ok, a_ok, d_ok, pe, ae, de;
    int ai, lo, hi;
    for (int b = 0; b < W; b++)
      if (!m_mask[b] && (p[b] != m_slot[0][b])) region = 1'b0;
    for (int j = 1; j < 4; j++)
      if (m_ctl[6+j] && (p == m_slot[j])) region = 1'b1;
    pc_ok = iv && (region != m_ctl[0]);
    ai = int'(a); lo = int'(m_lo); hi = int'(m_hi);
    a_ok = ov && ((m_ctl[2] && ai == lo) ||
                  (m_ctl[3] && ai >= lo && ai <= hi) ||
                  (m_ctl[4] && (ai < lo || ai > hi)));
    d_ok = ov && ((d == m_dref) != m_ctl[5]);
    pe = m_ctl[1]; ae = |m_ctl[4:2]; de = m_ctl[6];
    return (pe || ae || de) && (!pe || pc_ok) && (!ae || a_ok) && (!de || d_ok);
  endfunction

  task automatic check(string req, logic got, logic exp, string ctx);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: trig_o=%b expected %b (%s)", req, got, exp, ctx);
    end
  endtask

  task automatic wr(logic [4:0] i, logic [WRW-1:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = i; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    case (i)
      5'h08: m_slot[0] = v[W-1:0];
      5'h09: m_slot[1] = v[W-1:0];
      5'h0A: m_slot[2] = v[W-1:0];
      5'h0B: m_slot[3] = v[W-1:0];
      5'h0C: m_mask    = v[W-1:0];
      5'h0D: m_lo      = v[W-1:0];
      5'h0E: m_hi      = v[W-1:0];
      5'h0F: m_dref    = v[W-1:0];
      5'h10: m_ctl     = v;
      default: ;
    endcase
  endtask

  // present one vector for one cycle, check the registered result
  task automatic vec(string req, bit iv, logic [W-1:0] p, bit ov,
                     logic [W-1:0] a, logic [W-1:0] d);
    bit exp;
    @(negedge clk);
    inst_valid = iv; pc = p; op_valid = ov; op_addr = a; op_data = d;
    exp = model(iv, p, ov, a, d);
    @(negedge clk);
    check(req, trig_o, exp, $sformatf("iv=%0b pc=%02h ov=%0b a=%02h d=%02h ctl=%03h",
                                     iv, p, ov, a, d, m_ctl));
  endtask

  initial begin
    for (int k = 0; k < 4; k++) m_slot[k] = '0;
    repeat (3) @(posedge clk);
    #1 check("R1", trig_o, 1'b0, "in reset");
    rst_n = 1'b1;
    // R1: nothing armed after reset
    for (int v = 0; v < 256; v += 15) vec("R1", 1'b1, 8'(v), 1'b1, 8'(v), 8'(v));

    wr(5'h08, 10'h0A0); wr(5'h09, 10'h033); wr(5'h0A, 10'h077); wr(5'h0B, 10'h0C5);
    wr(5'h0C, 10'h00F); wr(5'h0D, 10'h040); wr(5'h0E, 10'h090); wr(5'h0F, 10'h05A);

    // R2: slot 0 masked compare, two masks
    wr(5'h10, 10'h002);
    for (int v = 0; v < 256; v++) vec("R2", 1'b1, 8'(v), 1'b0, 8'h00, 8'h00);
    wr(5'h0C, 10'h081);
    for (int v = 0; v < 256; v++) vec("R2", 1'b1, 8'(v), 1'b0, 8'h00, 8'h00);

    // R4: enabled PC class without instruction strobe never fires
    for (int v = 0; v < 256; v += 3) vec("R4", 1'b0, 8'(v), 1'b1, 8'(v), 8'h5A);

    // R3: slots 1 and 3 valid, slot 2 left off; mask must not widen them
    wr(5'h10, 10'h282);
    for (int v = 0; v < 256; v++) vec("R3", 1'b1, 8'(v), 1'b0, 8'h00, 8'h00);
    wr(5'h10, 10'h102);
    for (int v = 0; v < 256; v++) vec("R3", 1'b1, 8'(v), 1'b0, 8'h00, 8'h00);

    // R5: inverted PC sense
    wr(5'h10, 10'h383);
    for (int v = 0; v < 256; v++) vec("R5", 1'b1, 8'(v), 1'b0, 8'h00, 8'h00);

    // R6: every address-mode combination, full address sweep
    for (int m = 0; m < 8; m++) begin
      wr(5'h10, 10'(m << 2));
      for (int v = 0; v < 256; v++) vec("R6", 1'b0, 8'h00, 1'b1, 8'(v), 8'h00);
      vec("R6", 1'b0, 8'h00, 1'b0, 8'h40, 8'h00);
    end

    // R7: data compare plain and inverted
    for (int inv = 0; inv < 2; inv++) begin
      wr(5'h10, 10'h040 | 10'(inv << 5));
      for (int v = 0; v < 256; v++) vec("R7", 1'b0, 8'h00, 1'b1, 8'h00, 8'(v));
      vec("R7", 1'b0, 8'h00, 1'b0, 8'h00, 8'h11);
    end

    // R8: all three classes ANDed
    wr(5'h0C, 10'h00F);
    wr(5'h10, 10'h04A);
    for (int pi = 0; pi < 3; pi++)
      for (int v = 0; v < 256; v += 17)
        for (int dd = 0; dd < 2; dd++)
          for (int s = 0; s < 4; s++)
            vec("R8", s[0], (pi == 0) ? 8'hA3 : (pi == 1) ? 8'h33 : 8'h00, s[1],
                8'(v), 8'h5A + 8'(dd));

    // R9: one-cycle registered latency
    wr(5'h10, 10'h002);
    vec("R9", 1'b1, 8'h00, 1'b0, 8'h00, 8'h00);
    @(negedge clk);
    inst_valid = 1'b1; pc = 8'hA5;
    #1 check("R9", trig_o, 1'b0, "before capturing edge");
    @(posedge clk);
    #1 check("R9", trig_o, 1'b1, "after capturing edge");
    @(negedge clk);
    pc = 8'h00;
    @(posedge clk);
    #1 check("R9", trig_o, 1'b0, "one cycle after match removed");

    // R10: writes outside the map leave configuration untouched
    wr(5'h07, 10'h3FF); wr(5'h11, 10'h3FF); wr(5'h00, 10'h3FF); wr(5'h1F, 10'h3FF);
    for (int v = 0; v < 256; v += 5) vec("R10", 1'b1, 8'(v), 1'b1, 8'(v), 8'h00);
    vec("R10", 1'b1, 8'hA7, 1'b0, 8'h00, 8'h00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish, got hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule